// File: doc/BRIEF.md
# Pattern-Table Bank Mapper for a Tile Video Processor

This block sits between the pattern-table port of a tile-based video processor and a large CHR RAM. Each access request carries a 14-bit processor address. Requests below 0x2000 are pattern fetches. These are translated through one of eight window layouts, built from eight bank registers, an externally held 4 KB bank number and two fetch-driven tile latches. The translated address is then clipped to a programmable usable size. Requests at 0x2000 and above are nametable accesses. They go either to the small on-board nametable memory, following a 2-bit mirroring setting, or to the top 4 KB of CHR RAM when four-screen operation is selected.

Bank values come in on a plain parallel write port, with the register number given on `bank_idx` (0..7). The layout, size code, write enable and mirroring setting are static inputs. A write to CHR RAM from the pattern side is passed on only while the write enable is set. Every result is registered and appears one cycle after its request.

Top module: `ppu_chrmap_top`

## Requirements
- R1: After reset, out_valid is low and all eight bank registers and both tile latches hold zero. With bank_wr high, bank_val loads into the register numbered bank_idx (0..7) at that clock edge.
- R2: A request sampled with req high at a rising edge gives out_valid high and its results in the following cycle. After a cycle with req low, out_valid, chr_we and ciram_we are low.
- R3: In a pattern access (ppu_addr[13]=0), a window of S KB with bank value v gives raw = (v >> log2 S) * S KB + (ppu_addr mod S KB). Layout 0 uses a single 8 KB window from bank 0.
- R4: Layout 1 maps both 4 KB halves with ext_bank taken as a 4 KB bank number directly, so raw = ext_bank * 4096 + ppu_addr[11:0].
- R5: In layout 2, 0x0000-0x07FF is a 2 KB window from bank 2's neighbour bank 0, and 0x0800-0x0FFF is a 2 KB window from bank 2. 0x1000-0x1FFF is split into 1 KB windows from banks 4..7, chosen by ppu_addr[11:10].
- R6: Layout 3 mirrors layout 2. The low 4 KB holds 1 KB windows from banks 4..7, chosen by ppu_addr[11:10]. 0x1000 and 0x1800 hold 2 KB windows from bank 0 and bank 2.
- R7: Layout 4 uses a 4 KB window from bank 0 at the low half and a 4 KB window from bank 4 at the high half.
- R8: Layout 5 uses 4 KB windows. The low half takes bank 0, or bank 1 when tile latch 0 is set. The high half takes bank 4, or bank 5 when tile latch 1 is set. A pattern read (not a write) with ppu_addr[11:4]=0xFD clears the latch of half ppu_addr[12]; with 0xFE it sets that latch. The change applies from the next request on.
- R9: Layout 6 uses four 2 KB windows from banks 0, 2, 4 and 6, chosen by ppu_addr[12:11].
- R10: Layout 7 uses eight 1 KB windows from banks 0..7, chosen by ppu_addr[12:10].
- R11: A pattern access outputs raw AND L, where L = ((((NOT size_code) AND 0x3F) + 1) * 8192 - 1) AND (2^CHR_AW - 1).
- R12: A pattern access drives chr_we = ppu_wr AND chr_wr_en. chr_we and ciram_we are never high together.
- R13: With four_screen set, a nametable access goes to CHR RAM at 2^CHR_AW - 4096 + ppu_addr[11:0]. It is not size-clipped, chr_we = ppu_wr, and ciram_sel = 0.
- R14: With four_screen clear, a nametable access gives ciram_sel = 1, ciram_we = ppu_wr, chr_addr = 0, chr_we = 0 and ciram_addr = {page, ppu_addr[9:0]}. The page is ppu_addr[10] for mirror_cfg 0, ppu_addr[11] for 1, 0 for 2 and 1 for 3. A pattern access gives ciram_sel, ciram_addr and ciram_we all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bank_wr | input | 1 | Bank register write strobe |
| bank_idx | input | 3 | Bank register number 0..7 |
| bank_val | input | BANK_W | Bank value to store |
| mode | input | 3 | Window layout 0..7 |
| ext_bank | input | BANK_W | Externally held 4 KB bank number (layout 1) |
| size_code | input | 6 | Usable-size code, inverted 8 KB unit count minus one |
| chr_wr_en | input | 1 | Allows pattern writes to CHR RAM |
| mirror_cfg | input | 2 | Nametable mirroring setting |
| four_screen | input | 1 | Nametables in the top 4 KB of CHR RAM |
| req | input | 1 | Access request |
| ppu_addr | input | 14 | Processor address |
| ppu_wr | input | 1 | Access is a write |
| out_valid | output | 1 | Result of last cycle's request |
| chr_addr | output | CHR_AW | CHR RAM byte address |
| chr_we | output | 1 | CHR RAM write strobe |
| ciram_sel | output | 1 | Access targets on-board nametable memory |
| ciram_addr | output | 11 | On-board nametable address |
| ciram_we | output | 1 | On-board nametable write strobe |

## Verification
The assertions assume that the layout, size code, mirroring setting and external bank do not change in the same cycle as a request that depends on them. They also assume that a bank write and a request reading that bank never share an edge. The stimulus meets this by changing configuration only in cycles with req low, and by issuing bank writes in their own idle cycles. The tile-latch properties take the latch to be changed only by pattern reads. The bench therefore includes a pattern write to a trigger address and confirms that the selected bank stays the same.

// File: rtl/ppu_chrmap_pkg.sv
package ppu_chrmap_pkg;

    localparam int NUM_BANKS = 8;

    typedef enum logic [2:0] {
        LAY_8K        = 3'd0,
        LAY_EXT4K     = 3'd1,
        LAY_LO2K_HI1K = 3'd2,
        LAY_LO1K_HI2K = 3'd3,
        LAY_4K        = 3'd4,
        LAY_4K_TILE   = 3'd5,
        LAY_2K        = 3'd6,
        LAY_1K        = 3'd7
    } layout_e;

    typedef enum logic [1:0] {
        ARR_HORZ    = 2'd0,
        ARR_VERT    = 2'd1,
        ARR_SOLO_LO = 2'd2,
        ARR_SOLO_HI = 2'd3
    } arrange_e;

    // Window choice for one pattern fetch: source and log2 of size in KB
    typedef struct packed {
        logic       from_ext;
        logic [2:0] idx;
        logic [1:0] lg;
    } win_t;

    function automatic win_t pick_window(layout_e lay, logic [2:0] slot, logic [1:0] tl);
        win_t w;
        w.from_ext = 1'b0;
        w.idx      = 3'd0;
        w.lg       = 2'd0;
        case (lay)
            LAY_8K: begin
                w.idx = 3'd0; w.lg = 2'd3;
            end
            LAY_EXT4K: begin
                w.from_ext = 1'b1; w.lg = 2'd2;
            end
            LAY_LO2K_HI1K: begin
                if (slot[2]) begin w.idx = {1'b1, slot[1:0]}; w.lg = 2'd0; end
                else         begin w.idx = {1'b0, slot[1], 1'b0}; w.lg = 2'd1; end
            end
            LAY_LO1K_HI2K: begin
                if (!slot[2]) begin w.idx = {1'b1, slot[1:0]}; w.lg = 2'd0; end
                else          begin w.idx = {1'b0, slot[1], 1'b0}; w.lg = 2'd1; end
            end
            LAY_4K: begin
                w.idx = {slot[2], 2'b00}; w.lg = 2'd2;
            end
            LAY_4K_TILE: begin
                w.idx = {slot[2], 1'b0, tl[slot[2]]}; w.lg = 2'd2;
            end
            LAY_2K: begin
                w.idx = {slot[2:1], 1'b0}; w.lg = 2'd1;
            end
            default: begin
                w.idx = slot; w.lg = 2'd0;
            end
        endcase
        return w;
    endfunction

    function automatic arrange_e decode_mirror(logic [1:0] cfg);
        return arrange_e'((cfg < 2'd2) ? (cfg ^ 2'b01) : cfg);
    endfunction

endpackage

// File: rtl/ppu_chrmap_bank_regs.sv
module ppu_chrmap_bank_regs
    import ppu_chrmap_pkg::*;
#(
    parameter int BANK_W = 8
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 wr,
    input  logic [2:0]                           idx,
    input  logic [BANK_W-1:0]                    val,
    output logic [NUM_BANKS-1:0][BANK_W-1:0]     banks
);

    always_ff @(posedge clk) begin
        if (rst) begin
            banks <= '0;
        end else if (wr) begin
            for (int i = 0; i < NUM_BANKS; i++) begin
                if (idx == 3'(i)) banks[i] <= val;
            end
        end
    end

    // R1: a write lands in the addressed register
    assert_bank_load_R1: assert property (@(posedge clk) disable iff (rst)
        wr |=> (banks[$past(idx)] == $past(val)));

endmodule

// File: rtl/ppu_chrmap_tile_latch.sv
module ppu_chrmap_tile_latch (
    input  logic        clk,
    input  logic        rst,
    input  logic        fetch,
    input  logic [12:0] addr,
    output logic [1:0]  tl
);

    localparam logic [7:0] TAG_CLR = 8'hFD;
    localparam logic [7:0] TAG_SET = 8'hFE;

    always_ff @(posedge clk) begin
        if (rst) begin
            tl <= 2'b00;
        end else if (fetch) begin
            for (int h = 0; h < 2; h++) begin
                if (addr[12] == 1'(h)) begin
                    if (addr[11:4] == TAG_CLR)      tl[h] <= 1'b0;
                    else if (addr[11:4] == TAG_SET) tl[h] <= 1'b1;
                end
            end
        end
    end

    assert_tile_set_lo_R8: assert property (@(posedge clk) disable iff (rst)
        (fetch && !addr[12] && addr[11:4] == TAG_SET) |=> tl[0]);
    assert_tile_clr_hi_R8: assert property (@(posedge clk) disable iff (rst)
        (fetch && addr[12] && addr[11:4] == TAG_CLR) |=> !tl[1]);
    assert_tile_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !fetch |=> $stable(tl));

endmodule

// File: rtl/ppu_chrmap_window.sv
module ppu_chrmap_window
    import ppu_chrmap_pkg::*;
#(
    parameter int BANK_W = 8,
    parameter int OUT_W  = 18
) (
    input  logic [2:0]                       lay,
    input  logic [12:0]                      addr,
    input  logic [NUM_BANKS-1:0][BANK_W-1:0] banks,
    input  logic [BANK_W-1:0]                ext_bank,
    input  logic [1:0]                       tile_lat,
    output logic [OUT_W-1:0]                 raw
);

    localparam int RAW_W = BANK_W + 13;

    win_t              w;
    logic [BANK_W-1:0] num;
    logic [4:0]        sh;
    logic [RAW_W-1:0]  base;
    logic [RAW_W-1:0]  offs;

    always_comb begin
        w    = pick_window(layout_e'(lay), addr[12:10], tile_lat);
        num  = w.from_ext ? ext_bank : banks[w.idx];
        sh   = 5'd10 + {3'b000, w.lg};
        if (w.from_ext) base = RAW_W'(num) << 12;
        else            base = (RAW_W'(num) >> w.lg) << sh;
        offs = RAW_W'(addr) & ((RAW_W'(1) << sh) - RAW_W'(1));
        raw  = OUT_W'(base | offs);
    end

endmodule

// File: rtl/ppu_chrmap_nt.sv
module ppu_chrmap_nt
    import ppu_chrmap_pkg::*;
#(
    parameter int CHR_AW = 18
) (
    input  logic [11:0]       offs,
    input  logic [1:0]        cfg,
    input  logic              four_screen,
    output logic              to_ciram,
    output logic [10:0]       ciram_a,
    output logic [CHR_AW-1:0] fs_addr
);

    arrange_e arr;
    logic     page;

    always_comb begin
        arr = decode_mirror(cfg);
        case (arr)
            ARR_HORZ:    page = offs[11];
            ARR_VERT:    page = offs[10];
            ARR_SOLO_LO: page = 1'b0;
            default:     page = 1'b1;
        endcase
        to_ciram = !four_screen;
        ciram_a  = {page, offs[9:0]};
        fs_addr  = {{(CHR_AW-12){1'b1}}, offs};
    end

endmodule

// File: rtl/ppu_chrmap_top.sv
module ppu_chrmap_top
    import ppu_chrmap_pkg::*;
#(
    parameter int BANK_W = 8,
    parameter int CHR_AW = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bank_wr,
    input  logic [2:0]        bank_idx,
    input  logic [BANK_W-1:0] bank_val,
    input  logic [2:0]        mode,
    input  logic [BANK_W-1:0] ext_bank,
    input  logic [5:0]        size_code,
    input  logic              chr_wr_en,
    input  logic [1:0]        mirror_cfg,
    input  logic              four_screen,
    input  logic              req,
    input  logic [13:0]       ppu_addr,
    input  logic              ppu_wr,
    output logic              out_valid,
    output logic [CHR_AW-1:0] chr_addr,
    output logic              chr_we,
    output logic              ciram_sel,
    output logic [10:0]       ciram_addr,
    output logic              ciram_we
);

    localparam int LIM_W = (CHR_AW > 20) ? CHR_AW : 20;

    logic [NUM_BANKS-1:0][BANK_W-1:0] banks;
    logic [1:0]                       tl;
    logic                             fetch;
    logic [CHR_AW-1:0]                raw;
    logic                             to_ciram;
    logic [10:0]                      nt_a;
    logic [CHR_AW-1:0]                fs_addr;
    logic [5:0]                       inv_code;
    logic [LIM_W-1:0]                 units;
    logic [CHR_AW-1:0]                lim;
    logic [CHR_AW-1:0]                pat_addr;

    assign fetch = req && !ppu_addr[13] && !ppu_wr;

    ppu_chrmap_bank_regs #(.BANK_W(BANK_W)) u_banks (
        .clk(clk), .rst(rst), .wr(bank_wr), .idx(bank_idx), .val(bank_val), .banks(banks)
    );

    ppu_chrmap_tile_latch u_tile (
        .clk(clk), .rst(rst), .fetch(fetch), .addr(ppu_addr[12:0]), .tl(tl)
    );

    ppu_chrmap_window #(.BANK_W(BANK_W), .OUT_W(CHR_AW)) u_win (
        .lay(mode), .addr(ppu_addr[12:0]), .banks(banks), .ext_bank(ext_bank),
        .tile_lat(tl), .raw(raw)
    );

    ppu_chrmap_nt #(.CHR_AW(CHR_AW)) u_nt (
        .offs(ppu_addr[11:0]), .cfg(mirror_cfg), .four_screen(four_screen),
        .to_ciram(to_ciram), .ciram_a(nt_a), .fs_addr(fs_addr)
    );

    always_comb begin
        inv_code = ~size_code;
        units    = {{(LIM_W-6){1'b0}}, inv_code} + LIM_W'(1);
        lim      = CHR_AW'((units << 13) - LIM_W'(1));
        pat_addr = raw & lim;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            chr_addr   <= '0;
            chr_we     <= 1'b0;
            ciram_sel  <= 1'b0;
            ciram_addr <= '0;
            ciram_we   <= 1'b0;
        end else begin
            out_valid <= req;
            if (req) begin
                if (!ppu_addr[13]) begin
                    chr_addr   <= pat_addr;
                    chr_we     <= ppu_wr && chr_wr_en;
                    ciram_sel  <= 1'b0;
                    ciram_addr <= '0;
                    ciram_we   <= 1'b0;
                end else if (to_ciram) begin
                    chr_addr   <= '0;
                    chr_we     <= 1'b0;
                    ciram_sel  <= 1'b1;
                    ciram_addr <= nt_a;
                    ciram_we   <= ppu_wr;
                end else begin
                    chr_addr   <= fs_addr;
                    chr_we     <= ppu_wr;
                    ciram_sel  <= 1'b0;
                    ciram_addr <= '0;
                    ciram_we   <= 1'b0;
                end
            end else begin
                chr_we   <= 1'b0;
                ciram_we <= 1'b0;
            end
        end
    end

    assert_valid_follows_req_R2: assert property (@(posedge clk) disable iff (rst)
        req |=> out_valid);
    assert_quiet_when_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !req |=> (!out_valid && !chr_we && !ciram_we));
    assert_flat_8k_offset_R3: assert property (@(posedge clk) disable iff (rst)
        (req && !ppu_addr[13] && mode == 3'd0 && size_code == 6'd0)
        |=> (chr_addr[12:0] == $past(ppu_addr[12:0])));
    assert_clip_to_size_R11: assert property (@(posedge clk) disable iff (rst)
        (req && !ppu_addr[13]) |=> (chr_addr <= $past(lim)));
    assert_write_gate_R12: assert property (@(posedge clk) disable iff (rst)
        (req && !ppu_addr[13] && !chr_wr_en) |=> !chr_we);
    assert_strobe_excl_R12: assert property (@(posedge clk) disable iff (rst)
        !(chr_we && ciram_we));
    assert_four_screen_top_R13: assert property (@(posedge clk) disable iff (rst)
        (req && ppu_addr[13] && four_screen)
        |=> (!ciram_sel && (&chr_addr[CHR_AW-1:12]) && chr_addr[11:0] == $past(ppu_addr[11:0])));
    assert_single_page_R14: assert property (@(posedge clk) disable iff (rst)
        (req && ppu_addr[13] && !four_screen && mirror_cfg == 2'd2)
        |=> (ciram_sel && !ciram_addr[10]));

endmodule

// File: tb/tb_ppu_chrmap_top.sv
module tb_ppu_chrmap_top;

    localparam int AW = 18;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bank_wr = 1'b0;
    logic [2:0]  bank_idx = '0;
    logic [7:0]  bank_val = '0;
    logic [2:0]  mode = '0;
    logic [7:0]  ext_bank = '0;
    logic [5:0]  size_code = '0;
    logic        chr_wr_en = 1'b0;
    logic [1:0]  mirror_cfg = '0;
    logic        four_screen = 1'b0;
    logic        req = 1'b0;
    logic [13:0] ppu_addr = '0;
    logic        ppu_wr = 1'b0;
    logic        out_valid;
    logic [AW-1:0] chr_addr;
    logic        chr_we;
    logic        ciram_sel;
    logic [10:0] ciram_addr;
    logic        ciram_we;

    always #4 clk = ~clk;

    ppu_chrmap_top #(.BANK_W(8), .CHR_AW(AW)) dut (
        .clk(clk), .rst(rst), .bank_wr(bank_wr), .bank_idx(bank_idx), .bank_val(bank_val),
        .mode(mode), .ext_bank(ext_bank), .size_code(size_code), .chr_wr_en(chr_wr_en),
        .mirror_cfg(mirror_cfg), .four_screen(four_screen), .req(req), .ppu_addr(ppu_addr),
        .ppu_wr(ppu_wr), .out_valid(out_valid), .chr_addr(chr_addr), .chr_we(chr_we),
        .ciram_sel(ciram_sel), .ciram_addr(ciram_addr), .ciram_we(ciram_we)
    );

    typedef struct packed {
        logic [AW-1:0] chr;
        logic          cwe;
        logic          csel;
        logic [10:0]   cia;
        logic          ciwe;
        logic [7:0]    rq;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    int unsigned bk[8];
    bit   tlm[2];

    function automatic exp_t model(logic [13:0] a, logic w, int rq);
        exp_t e;
        longint unsigned v, sz, rawv, lim;
        bit pg;
        e = '0;
        e.rq = 8'(rq);
        v = 0; sz = 1024; rawv = 0;
        if (!a[13]) begin
            case (mode)
                3'd0: begin v = bk[0]; sz = 8192; end
                3'd1: begin v = 0; sz = 4096; end
                3'd2: if (a[12]) begin v = bk[4 + a[11:10]]; sz = 1024; end
                      else begin v = a[11] ? bk[2] : bk[0]; sz = 2048; end
                3'd3: if (!a[12]) begin v = bk[4 + a[11:10]]; sz = 1024; end
                      else begin v = a[11] ? bk[2] : bk[0]; sz = 2048; end
                3'd4: begin v = a[12] ? bk[4] : bk[0]; sz = 4096; end
                3'd5: begin
                    if (a[12]) v = tlm[1] ? bk[5] : bk[4];
                    else       v = tlm[0] ? bk[1] : bk[0];
                    sz = 4096;
                end
                3'd6: begin v = bk[2 * a[12:11]]; sz = 2048; end
                default: begin v = bk[a[12:10]]; sz = 1024; end
            endcase
            if (mode == 3'd1) rawv = longint'(ext_bank) * 4096 + (a % 4096);
            else rawv = (v / (sz / 1024)) * sz + (a % sz);
            lim = ((((~longint'(size_code)) & 63) + 1) * 8192 - 1) & ((64'd1 << AW) - 1);
            e.chr = AW'(rawv & lim);
            e.cwe = w & chr_wr_en;
        end else if (four_screen) begin
            e.chr = AW'((64'd1 << AW) - 4096 + longint'(a[11:0]));
            e.cwe = w;
        end else begin
            case (mirror_cfg)
                2'd0: pg = a[10];
                2'd1: pg = a[11];
                2'd2: pg = 1'b0;
                default: pg = 1'b1;
            endcase
            e.csel = 1'b1;
            e.cia  = {pg, a[9:0]};
            e.ciwe = w;
        end
        return e;
    endfunction

    task automatic issue(input logic [13:0] a, input logic w, input int rq);
        @(negedge clk);
        bank_wr  = 1'b0;
        req      = 1'b1;
        ppu_addr = a;
        ppu_wr   = w;
        q.push_back(model(a, w, rq));
        if (!a[13] && !w) begin
            if (a[11:4] == 8'hFD) tlm[a[12]] = 1'b0;
            else if (a[11:4] == 8'hFE) tlm[a[12]] = 1'b1;
        end
    endtask

    task automatic idle();
        @(negedge clk);
        req    = 1'b0;
        ppu_wr = 1'b0;
    endtask

    task automatic load_bank(input int i, input int unsigned v);
        idle();
        bank_wr  = 1'b1;
        bank_idx = 3'(i);
        bank_val = 8'(v);
        bk[i]    = v;
        idle();
        bank_wr  = 1'b0;
    endtask

    task automatic sweep(input int rq);
        issue(14'h0000, 1'b0, rq);
        issue(14'h03FF, 1'b0, rq);
        issue(14'h0555, 1'b0, rq);
        issue(14'h0A12, 1'b0, rq);
        issue(14'h0C34, 1'b0, rq);
        issue(14'h1000, 1'b0, rq);
        issue(14'h1456, 1'b0, rq);
        issue(14'h1BCD, 1'b0, rq);
        issue(14'h1FFF, 1'b0, rq);
        idle();
    endtask

    // Scoreboard monitor: pops one expected item per valid result
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (q.size() == 0) begin
                errors++;
                $display("FAIL R2: unexpected result chr_addr=%h, expected no result", chr_addr);
            end else begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (chr_addr !== e.chr || chr_we !== e.cwe || ciram_sel !== e.csel ||
                    ciram_addr !== e.cia || ciram_we !== e.ciwe) begin
                    errors++;
                    $display("FAIL R%0d: got chr=%h we=%b sel=%b cia=%h ciwe=%b, expected chr=%h we=%b sel=%b cia=%h ciwe=%b",
                             e.rq, chr_addr, chr_we, ciram_sel, ciram_addr, ciram_we,
                             e.chr, e.cwe, e.csel, e.cia, e.ciwe);
                end
            end
        end
    end

    task automatic expect_quiet();
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || chr_we !== 1'b0 || ciram_we !== 1'b0) begin
            errors++;
            $display("FAIL R2: idle cycle valid=%b chr_we=%b ciram_we=%b, expected 0 0 0",
                     out_valid, chr_we, ciram_we);
        end
    endtask

    initial begin
        for (int i = 0; i < 8; i++) bk[i] = 0;
        tlm[0] = 1'b0; tlm[1] = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        checks++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1: out_valid=%b after reset, expected 0", out_valid);
        end
        // R1: banks reset to zero, seen through layout 7 and layout 5
        mode = 3'd7;
        issue(14'h1C77, 1'b0, 1);
        idle();
        mode = 3'd5;
        issue(14'h0123, 1'b0, 1);
        issue(14'h1123, 1'b0, 1);
        idle();
        // R1: load all banks
        load_bank(0, 8'h2B); load_bank(1, 8'h51); load_bank(2, 8'h66); load_bank(3, 8'h17);
        load_bank(4, 8'h9C); load_bank(5, 8'hC3); load_bank(6, 8'h3A); load_bank(7, 8'hF5);
        mode = 3'd7; sweep(1);
        expect_quiet();                 // R2
        mode = 3'd0; sweep(3);          // R3
        mode = 3'd1; ext_bank = 8'h2D; sweep(4);  // R4
        mode = 3'd2; sweep(5);          // R5
        mode = 3'd3; sweep(6);          // R6
        mode = 3'd4; sweep(7);          // R7
        mode = 3'd6; sweep(9);          // R9
        mode = 3'd7; sweep(10);         // R10
        // R8: tile latches
        mode = 3'd5; sweep(8);
        issue(14'h0FD0, 1'b0, 8);
        issue(14'h0FE8, 1'b0, 8);
        issue(14'h0100, 1'b0, 8);
        issue(14'h1FE0, 1'b0, 8);
        issue(14'h1200, 1'b0, 8);
        issue(14'h0FD3, 1'b1, 8);       // R8: a write must not clear latch 0
        issue(14'h0200, 1'b0, 8);
        issue(14'h1FD5, 1'b0, 8);
        issue(14'h1200, 1'b0, 8);
        idle();
        // R11: size clipping
        mode = 3'd7; size_code = 6'b111100;
        issue(14'h1C00, 1'b0, 11);
        issue(14'h0BCD, 1'b0, 11);
        idle();
        size_code = 6'b111111;
        issue(14'h1FFF, 1'b0, 11);
        idle();
        size_code = 6'b100000;
        issue(14'h1C21, 1'b0, 11);
        idle();
        mode = 3'd1; ext_bank = 8'hC5; size_code = 6'd0;
        issue(14'h0ABC, 1'b0, 11);
        idle();
        // R12: write gating
        mode = 3'd7; chr_wr_en = 1'b0;
        issue(14'h0444, 1'b1, 12);
        idle();
        chr_wr_en = 1'b1;
        issue(14'h0444, 1'b1, 12);
        issue(14'h1555, 1'b0, 12);
        idle();
        chr_wr_en = 1'b0;
        // R13: four-screen nametables
        four_screen = 1'b1; size_code = 6'b111111;
        issue(14'h2000, 1'b0, 13);
        issue(14'h2C05, 1'b1, 13);
        issue(14'h3777, 1'b0, 13);
        idle();
        four_screen = 1'b0; size_code = 6'd0;
        // R14: mirroring
        for (int c = 0; c < 4; c++) begin
            mirror_cfg = 2'(c);
            issue(14'h2400, 1'b0, 14);
            issue(14'h2812, 1'b1, 14);
            issue(14'h2C3F, 1'b0, 14);
            idle();
        end
        expect_quiet();                 // R2
        repeat (3) @(negedge clk);
        if (q.size() != 0) begin
            errors++;
            $display("FAIL R2: %0d results missing, expected 0", q.size());
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R2: watchdog expired with %0d pending, expected completion", q.size());
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule